// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps four flag bits that tell software why the core last restarted or woke. Two status bits, `to_o` (time-out) and `pd_o` (power-down), take a fixed pattern for each reset or wake source. Two power-control bits, `pon_o` (power-on) and `bo_o` (brown-out), are sticky: each one is cleared only by its own event, and software sets it again afterwards. After a later reset, software reads all four bits and works out which source acted.

Every source enters as a one-cycle strobe and is taken on the next rising clock edge. When several strobes arrive in the same cycle, a fixed priority picks the one that sets the status pattern. A software write port loads the two power-control bits. A write in the same cycle as any reset strobe is dropped. A configuration input can disable brown-out detection. While it does, the brown-out strobe is ignored.

Top module: `rst_cause_flags`

## Requirements
- R1: While `rst_ni` is low, the outputs are to=1, pd=1, pon=0 and bo=0, and they take these values without waiting for a clock edge.
- R2: A `por_i` strobe gives to=1, pd=1 and pon=0 after the next edge. It leaves bo unchanged.
- R3: A `bor_i` strobe with `bor_en_i`=1 gives to=1, pd=1 and bo=0. It leaves pon unchanged. With `bor_en_i`=0 the strobe has no effect on any output.
- R4: A `wdt_rst_i` strobe gives to=0 and pd=1.
- R5: A `wdt_wake_i` strobe gives to=0 and pd=0.
- R6: An `ext_rst_run_i` strobe leaves all four outputs unchanged.
- R7: An `ext_wake_slp_i` strobe gives to=1 and pd=0.
- R8: A `sleep_i` strobe gives to=1 and pd=0.
- R9: With `sw_wr_i`=1 and no reset strobe, pon takes `sw_pon_i` and bo takes `sw_bo_i` after the next edge. to and pd are unchanged.
- R10: A software write in the same cycle as any reset strobe is discarded. The reset strobes are por, enabled bor, wdt_rst, wdt_wake, ext_wake_slp and ext_rst_run. A `sleep_i` strobe does not block a write.
- R11: Simultaneous strobes set to and pd by the first one present in this order: por, bor, wdt_rst, wdt_wake, ext_wake_slp, ext_rst_run, sleep. In a cycle with both por and enabled bor, pon and bo are both cleared.
- R12: With no strobe and no write, all four outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-on reset strobe |
| bor_i | input | 1 | Brown-out reset strobe |
| bor_en_i | input | 1 | Brown-out detection enabled |
| wdt_rst_i | input | 1 | Watchdog reset while running |
| wdt_wake_i | input | 1 | Watchdog wake-up from sleep |
| ext_rst_run_i | input | 1 | External reset while running |
| ext_wake_slp_i | input | 1 | External reset or interrupt wake-up while sleeping |
| sleep_i | input | 1 | Entry to sleep |
| sw_wr_i | input | 1 | Software write strobe for the power-control bits |
| sw_pon_i | input | 1 | Write data for the power-on bit |
| sw_bo_i | input | 1 | Write data for the brown-out bit |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| pon_o | output | 1 | Power-on flag |
| bo_o | output | 1 | Brown-out flag |

## Verification
Every strobe changes the outputs one edge later, so a wrong priority or a wrong pattern shows on `to_o`/`pd_o` in the cycle right after the strobe. A sticky bit that is cleared or set wrongly stays wrong until its own event or a later write. The stimulus therefore always reads the power-control bits after any event that should have left them alone. Writes are placed in the same cycle as each class of strobe, so a missing or wrongly placed write block shows up as a flipped `pon_o` or `bo_o` one cycle later.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int unsigned EVT_W = 7;
  // strobe index = priority rank, lowest wins
  localparam int unsigned EV_POR      = 0;
  localparam int unsigned EV_BOR      = 1;
  localparam int unsigned EV_WDT_RST  = 2;
  localparam int unsigned EV_WDT_WAKE = 3;
  localparam int unsigned EV_EXT_SLP  = 4;
  localparam int unsigned EV_EXT_RUN  = 5;
  localparam int unsigned EV_SLEEP    = 6;

  typedef enum logic [2:0] {
    CS_NONE, CS_POR, CS_BOR, CS_WDT_RST, CS_WDT_WAKE, CS_EXT_SLP, CS_EXT_RUN, CS_SLEEP
  } cause_e;
endpackage

// File: rtl/rcf_cause_enc.sv
module rcf_cause_enc
  import rcf_pkg::*;
(
  input  logic [EVT_W-1:0] evt_i,
  output cause_e           cause_o,
  output logic             rst_evt_o
);
  always_comb begin
    if      (evt_i[EV_POR])      cause_o = CS_POR;
    else if (evt_i[EV_BOR])      cause_o = CS_BOR;
    else if (evt_i[EV_WDT_RST])  cause_o = CS_WDT_RST;
    else if (evt_i[EV_WDT_WAKE]) cause_o = CS_WDT_WAKE;
    else if (evt_i[EV_EXT_SLP])  cause_o = CS_EXT_SLP;
    else if (evt_i[EV_EXT_RUN])  cause_o = CS_EXT_RUN;
    else if (evt_i[EV_SLEEP])    cause_o = CS_SLEEP;
    else                         cause_o = CS_NONE;
  end

  // every strobe but sleep restarts the core
  assign rst_evt_o = |evt_i[EV_EXT_RUN:EV_POR];
endmodule

// File: rtl/rcf_status.sv
module rcf_status
  import rcf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cause_e cause_i,
  output logic   to_o,
  output logic   pd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_o <= 1'b1;
      pd_o <= 1'b1;
    end else begin
      case (cause_i)
        CS_POR, CS_BOR:        begin to_o <= 1'b1; pd_o <= 1'b1; end
        CS_WDT_RST:            begin to_o <= 1'b0; pd_o <= 1'b1; end
        CS_WDT_WAKE:           begin to_o <= 1'b0; pd_o <= 1'b0; end
        CS_EXT_SLP, CS_SLEEP:  begin to_o <= 1'b1; pd_o <= 1'b0; end
        default:               ;
      endcase
    end
  end

  // R6
  ext_run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == CS_EXT_RUN) |=> ($stable(to_o) && $stable(pd_o)));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == CS_NONE) |=> ($stable(to_o) && $stable(pd_o)));
endmodule

// File: rtl/rcf_pwr.sv
module rcf_pwr #(
  parameter logic BO_RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic bor_i,
  input  logic rst_evt_i,
  input  logic wr_i,
  input  logic wr_pon_i,
  input  logic wr_bo_i,
  output logic pon_o,
  output logic bo_o
);
  logic wr_ok;
  assign wr_ok = wr_i & ~rst_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pon_o <= 1'b0;
    else if (por_i) pon_o <= 1'b0;
    else if (wr_ok) pon_o <= wr_pon_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bo_o <= BO_RST_VAL;
    else if (bor_i) bo_o <= 1'b0;
    else if (wr_ok) bo_o <= wr_bo_i;
  end

  // R2
  por_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> !pon_o);
  // R10
  wr_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_evt_i && !por_i && !bor_i) |=> ($stable(pon_o) && $stable(bo_o)));
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rcf_pkg::*;
#(
  parameter logic BO_RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic bor_i,
  input  logic bor_en_i,
  input  logic wdt_rst_i,
  input  logic wdt_wake_i,
  input  logic ext_rst_run_i,
  input  logic ext_wake_slp_i,
  input  logic sleep_i,
  input  logic sw_wr_i,
  input  logic sw_pon_i,
  input  logic sw_bo_i,
  output logic to_o,
  output logic pd_o,
  output logic pon_o,
  output logic bo_o
);
  logic [EVT_W-1:0] evt;
  logic             bor_act;
  logic             rst_evt;
  cause_e           cause;

  assign bor_act = bor_i & bor_en_i;

  always_comb begin
    evt              = '0;
    evt[EV_POR]      = por_i;
    evt[EV_BOR]      = bor_act;
    evt[EV_WDT_RST]  = wdt_rst_i;
    evt[EV_WDT_WAKE] = wdt_wake_i;
    evt[EV_EXT_SLP]  = ext_wake_slp_i;
    evt[EV_EXT_RUN]  = ext_rst_run_i;
    evt[EV_SLEEP]    = sleep_i;
  end

  rcf_cause_enc u_enc (
    .evt_i     (evt),
    .cause_o   (cause),
    .rst_evt_o (rst_evt)
  );

  rcf_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause),
    .to_o    (to_o),
    .pd_o    (pd_o)
  );

  rcf_pwr #(.BO_RST_VAL(BO_RST_VAL)) u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_i     (por_i),
    .bor_i     (bor_act),
    .rst_evt_i (rst_evt),
    .wr_i      (sw_wr_i),
    .wr_pon_i  (sw_pon_i),
    .wr_bo_i   (sw_bo_i),
    .pon_o     (pon_o),
    .bo_o      (bo_o)
  );

  // R4
  wdt_rst_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_i && !por_i && !bor_act) |=> (!to_o && pd_o));
  // R5
  wdt_wake_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_wake_i && !por_i && !bor_act && !wdt_rst_i) |=> (!to_o && !pd_o));
  // R3
  bor_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_i && !bor_en_i && !sw_wr_i) |=> $stable(bo_o));
  // R8
  sleep_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !rst_evt) |=> (to_o && !pd_o));
endmodule

// File: tb/rst_cause_flags_test.sv
module rst_cause_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  // row: [14:8] strobes {sleep,ext_slp,ext_run,wdt_wake,wdt_rst,bor,por},
  //      [7] bor_en, [6] wr, [5] wr_pon, [4] wr_bo, [3:0] expected {to,pd,pon,bo}
  localparam logic [14:0] VEC [NV] = '{
    {7'b0000000, 4'b1111, 4'b1111}, // R9
    {7'b0000000, 4'b1000, 4'b1111}, // R12
    {7'b0000100, 4'b1000, 4'b0111}, // R4
    {7'b0010000, 4'b1000, 4'b0111}, // R6
    {7'b1000000, 4'b1000, 4'b1011}, // R8
    {7'b0001000, 4'b1000, 4'b0011}, // R5
    {7'b0100000, 4'b1000, 4'b1011}, // R7
    {7'b0010000, 4'b1000, 4'b1011}, // R6
    {7'b0000010, 4'b1000, 4'b1110}, // R3
    {7'b0000100, 4'b1111, 4'b0110}, // R10
    {7'b1000000, 4'b1111, 4'b1011}, // R10
    {7'b0000010, 4'b0000, 4'b1011}, // R3
    {7'b0000001, 4'b1000, 4'b1101}, // R2
    {7'b0000001, 4'b1111, 4'b1101}, // R10
    {7'b1001100, 4'b1000, 4'b0101}, // R11
    {7'b1010000, 4'b1000, 4'b0101}, // R11
    {7'b0110000, 4'b1000, 4'b1001}, // R11
    {7'b0000011, 4'b1000, 4'b1100}, // R11
    {7'b0000000, 4'b1101, 4'b1101}, // R9
    {7'b0101000, 4'b1000, 4'b0001}  // R11
  };
  string tag [NV] = '{"R9","R12","R4","R6","R8","R5","R7","R6","R3","R10",
                      "R10","R3","R2","R10","R11","R11","R11","R11","R9","R11"};

  logic clk = 1'b0;
  logic rst_ni;
  logic por, bor, bor_en, wdt_rst, wdt_wake, ext_run, ext_slp, slp;
  logic wr, wpon, wbo;
  logic to, pd, pon, bo;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_flags uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .bor_i(bor), .bor_en_i(bor_en),
    .wdt_rst_i(wdt_rst), .wdt_wake_i(wdt_wake), .ext_rst_run_i(ext_run),
    .ext_wake_slp_i(ext_slp), .sleep_i(slp), .sw_wr_i(wr), .sw_pon_i(wpon),
    .sw_bo_i(wbo), .to_o(to), .pd_o(pd), .pon_o(pon), .bo_o(bo)
  );

  task automatic check(input string req, input logic [3:0] exp);
    total++;
    if ({to, pd, pon, bo} !== exp) begin
      bad++;
      $display("FAIL %s: actual={to,pd,pon,bo}=%b expected=%b", req, {to, pd, pon, bo}, exp);
    end
  endtask

  task automatic apply(input logic [14:0] v);
    {slp, ext_slp, ext_run, wdt_wake, wdt_rst, bor, por} = v[14:8];
    {bor_en, wr, wpon, wbo} = v[7:4];
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    apply({7'b0, 4'b1000, 4'b0000});
    #(CLK_PERIOD * 2);
    @(negedge clk);
    check("R1", 4'b1100);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12", 4'b1100);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check(tag[i], VEC[i][3:0]);
    end

    // strobes dropped: outputs must hold at 0001
    apply({7'b0, 4'b1000, 4'b0000});
    @(negedge clk);
    check("R12", 4'b0001);

    // brown-out disabled, with write: the write still lands (R3, R9)
    apply({7'b0000010, 4'b0111, 4'b0000});
    @(negedge clk);
    check("R3", 4'b0011);

    // asynchronous reset in mid-cycle
    apply({7'b0, 4'b1000, 4'b0000});
    #(CLK_PERIOD / 4);
    rst_ni = 1'b0;
    #1;
    check("R1", 4'b1100);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", 4'b1100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule